// File: doc/BRIEF.md
# Serial String Recognizer with Lockout

This block watches a single serial bit stream, one bit per rising clock edge, and raises a one-bit flag whenever the three most recent bits are 0 then 1 then 0. Detection overlaps, so a trailing 0 can also start the next match. A second pattern acts as a kill switch. Once the bits 1, 0, 0 arrive in a row, the machine drops into a trap state. It stays there, with the flag low, until a synchronous reset.

The block is a Moore machine with seven named states. IDLE is the state after reset. ZERO means the stream ends in 0 with no pending 1-0. ZO means it ends in 0-1. HIT means it ends in 0-1-0 and drives the flag. ONE means it ends in 1. ONEZ means it ends in 1-0 that did not follow a 0. LOCK is the trap.

The transitions, given as (state, bit) → next state, are:
- IDLE,0→ZERO; IDLE,1→ONE
- ZERO,0→ZERO; ZERO,1→ZO
- ZO,0→HIT; ZO,1→ONE
- HIT,0→LOCK; HIT,1→ZO
- ONE,0→ONEZ; ONE,1→ONE
- ONEZ,0→LOCK; ONEZ,1→ZO
- LOCK,x→LOCK

Any unused state code returns to IDLE. The flag is registered in step with the state. It therefore shows the bits sampled up to and including the most recent edge.

Top module: `serial_lockout_recognizer`

## Requirements
- R1: While reset is high at a rising edge, the machine returns to its initial state and the flag reads 0 after that edge.
- R2: The flag rises just after the edge that samples the final 0 of a 0,1,0 run, and not before that edge.
- R3: Detection overlaps: the stream 0,1,0,1,0 raises the flag after the third bit and again after the fifth bit, and the flag is 0 after the fourth bit.
- R4: After the bits 1,0,0 have been sampled in a row, the flag stays 0 for every later bit until reset, whatever those bits are.
- R5: Reset clears the lockout, and a following 0,1,0 raises the flag again.
- R6: A stream ending in 0,1 followed by 1,0,0 locks the machine, because the 1 reuses the "ends in 1" state as the prefix of 1,0,0.
- R7: A 1,0 that did not follow a 0, followed by 1,0, raises the flag, because 1,0,1,0 ends in 0,1,0.
- R8: Bits 00101010010, applied first bit first, give flags 00010101000. Bits 11011010010 give flags 00000001000. Each flag is read after the edge that samples the bit at the same position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit, sampled on every rising edge |
| match_out | output | 1 | Registered flag, high while the state is HIT |

## Verification
Four 11-bit streams are each run from reset. The two reference streams exercise every transition between the detecting states and show that the flag drops for good once 1,0,0 appears. An alternating stream shows overlap and that a 1 after HIT goes back to ZO rather than ONE. A stream with 0,1,1,0,0 sets the ONE prefix reuse apart from a design that only locks after a 0-started run. Directed runs look at the flag just before and just after the detecting edge to catch a one-cycle shift. They also run a long mixed stream after lockout, and they check that reset frees the trap.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ZERO = 3'd1,
        ST_ZO   = 3'd2,
        ST_HIT  = 3'd3,
        ST_ONE  = 3'd4,
        ST_ONEZ = 3'd5,
        ST_LOCK = 3'd6
    } rsr_state_e;

endpackage

// File: rtl/rsr_next.sv
module rsr_next
    import rsr_pkg::*;
(
    input  rsr_state_e cur_st,
    input  logic       bit_in,
    output rsr_state_e nxt_st
);

    always_comb begin
        nxt_st = ST_IDLE;
        unique case (cur_st)
            ST_IDLE: nxt_st = bit_in ? ST_ONE  : ST_ZERO;
            ST_ZERO: nxt_st = bit_in ? ST_ZO   : ST_ZERO;
            ST_ZO:   nxt_st = bit_in ? ST_ONE  : ST_HIT;
            ST_HIT:  nxt_st = bit_in ? ST_ZO   : ST_LOCK;
            ST_ONE:  nxt_st = bit_in ? ST_ONE  : ST_ONEZ;
            ST_ONEZ: nxt_st = bit_in ? ST_ZO   : ST_LOCK;
            ST_LOCK: nxt_st = ST_LOCK;
            default: nxt_st = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/rsr_outdec.sv
module rsr_outdec
    import rsr_pkg::*;
(
    input  rsr_state_e st,
    output logic       flag
);

    always_comb begin
        flag = 1'b0;
        unique case (st)
            ST_HIT:  flag = 1'b1;
            default: flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/serial_lockout_recognizer.sv
module serial_lockout_recognizer
    import rsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic match_out
);

    rsr_state_e state_q;
    rsr_state_e state_d;
    logic       flag_d;

    rsr_next u_next (
        .cur_st (state_q),
        .bit_in (bit_in),
        .nxt_st (state_d)
    );

    rsr_outdec u_dec (
        .st   (state_d),
        .flag (flag_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) match_out <= 1'b0;
        else     match_out <= flag_d;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!match_out && state_q == ST_IDLE));

    a_r2_flag_needs_010: assert property (@(posedge clk) disable iff (rst)
        match_out |-> (!$past(bit_in) && $past(bit_in, 2)));

    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCK) |=> (state_q == ST_LOCK && !match_out));

    a_r4_hit_then_zero_locks: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIT && !bit_in) |=> (state_q == ST_LOCK));

    a_r3_hit_then_one_rearms: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIT && bit_in) |=> (state_q == ST_ZO && !match_out));

endmodule

// File: tb/sim_serial_lockout_recognizer.sv
module sim_serial_lockout_recognizer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic match_out;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    serial_lockout_recognizer u0 (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .match_out (match_out)
    );

    // first bit is the MSB
    localparam logic [10:0] STIM [4] = '{
        11'b00101010010, 11'b11011010010, 11'b01010111010, 11'b01100101010 };
    localparam logic [10:0] EXPV [4] = '{
        11'b00010101000, 11'b00000001000, 11'b00101000001, 11'b00000000000 };

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; bit_in = 1'b0;
        @(posedge clk); @(posedge clk); #5;
        chk("R1", match_out, 1'b0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic step(input logic b);
        @(negedge clk); bit_in = b;
        @(posedge clk); #5;
    endtask

    initial begin
        string tag;
        do_reset();
        for (int v = 0; v < 4; v++) begin
            tag = (v < 2) ? "R8" : (v == 2) ? "R3" : "R6";
            do_reset();
            for (int i = 10; i >= 0; i--) begin
                step(STIM[v][i]);
                chk(tag, match_out, EXPV[v][i]);
            end
        end

        // R2: flag low before the detecting edge, high after it
        do_reset();
        step(1'b0); step(1'b1);
        @(negedge clk); bit_in = 1'b0; #5;
        chk("R2", match_out, 1'b0);
        @(posedge clk); #5;
        chk("R2", match_out, 1'b1);

        // R7: 1,0,1,0 from reset
        do_reset();
        step(1'b1); step(1'b0); step(1'b1);
        chk("R7", match_out, 1'b0);
        step(1'b0);
        chk("R7", match_out, 1'b1);

        // R4: long mixed stream after lockout
        do_reset();
        step(1'b1); step(1'b0); step(1'b0);
        for (int k = 0; k < 60; k++) begin
            step(((k % 3) == 1) || ((k % 5) == 0));
            chk("R4", match_out, 1'b0);
        end

        // R5: reset frees the trap
        do_reset();
        step(1'b0); step(1'b1); step(1'b0);
        chk("R5", match_out, 1'b1);

        // R1: reset in the middle of a hit
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #5;
        chk("R1", match_out, 1'b0);
        @(negedge clk); rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule